// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Transmitter (Clock Master)

This block drives a stereo audio serial link as the clock master. A system-clock enable (`bit_tick`) paces it. The block makes a bit clock from that enable, derives a word clock, and shifts left and right samples out MSB first on a single data line. Four framing formats can be selected: I2S, DSP (short frame pulse), right-justified and left-justified. The word length, the frame length and the offset of the data from frame start can all be programmed.

Samples arrive as a 32-bit left/right pair through a ready/valid handshake into a one-entry holding register, and one pair is consumed per frame. The configuration is captured at the start of every frame, so software may change it at any time without tearing a frame apart. A drive-enable output lets the pad float the data line while no data bit is being sent.

Top module: `asp_tx_master`

## Requirements
- R1: While reset is held: `bclk`, `wclk`, `sdata` and `sdata_oe` are 0 and `smp_ready` is 1.
- R2: `bclk` toggles on every clock edge where `bit_tick` is 1 and holds otherwise. `wclk`, `sdata` and `sdata_oe` change only at a falling edge of `bclk`. With `bit_tick` high every second cycle, the falling edges are 4 clocks apart.
- R3: `cfg_fmt` selects the format: 00 is I2S (`wclk` low for the left half, high for the right half); 01 is DSP (`wclk` high only during bit clock 0 of the frame); 10 is right-justified and 11 is left-justified (both with `wclk` high for the left half).
- R4: `cfg_wlen` 00/01/10/11 selects a word of 16/20/24/32 bits. The word is the low W bits of `smp_left`/`smp_right` and is sent MSB first.
- R5: When `cfg_frame256`=0 the frame is 2W+off bit clocks in DSP and 2(W+off+lead) in the other formats, where lead is 1 for I2S and 0 otherwise. When `cfg_frame256`=1 the frame is 256 bit clocks and each half is 128.
- R6: The left word starts at bit clock off+lead. In DSP the right word follows the left word directly. In I2S and left-justified it starts half a frame after the left word. In right-justified each word ends off bit clocks before the end of its half, with the start clamped at 0. Bits beyond the end of the frame are dropped, and where the two words overlap the left word wins.
- R7: An offset above the limit is clamped to the limit. The limit is 17 (16 for DSP) when `cfg_frame256`=0, and 242 (241 for DSP) when `cfg_frame256`=1.
- R8: Outside data bits `sdata` is 0. With `cfg_hiz`=1, `sdata_oe` is 1 only during data bits. With `cfg_hiz`=0 it is 1 for every bit clock once framing has started.
- R9: `smp_ready` is 1 exactly when the holding register is empty. An accepted pair is sent in the next frame to start, and the register empties at that frame start. If it is empty at frame start, zeros are sent in the data bits.
- R10: The configuration inputs are sampled only at frame start. A change in mid-frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Enable that toggles the bit clock |
| cfg_fmt | input | 2 | Framing format code |
| cfg_wlen | input | 2 | Word-length code |
| cfg_frame256 | input | 1 | 1: 256-bit-clock frame, 0: minimal frame |
| cfg_offset | input | 8 | Data offset in bit clocks from frame start |
| cfg_hiz | input | 1 | Release the data line outside data bits |
| smp_left | input | 32 | Left sample, right-aligned |
| smp_right | input | 32 | Right sample, right-aligned |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding register empty |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock |
| sdata | output | 1 | Serial data, changes on falling `bclk` |
| sdata_oe | output | 1 | Drive enable for `sdata` |

## Verification
The bench runs each format with its own word length, offset and frame mode, and sends random full 32-bit samples. Any wrong bit order or any leak of bits above the word length into the output therefore shows up. Offsets beyond the legal limit in both frame modes separate clamping from wrap-around. A run of frames with no sample offered separates an empty buffer, which must send zeros, from stale data. A configuration change halfway through a DSP frame shows whether the frame geometry is latched or live, because the word clock and data positions differ sharply between the two formats.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int POS_W = 10;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_DSP = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_LJ  = 2'b11
    } fmt_e;

    // Frame geometry, fixed for one frame
    typedef struct packed {
        pos_t len;    // bit clocks per frame
        pos_t half;   // first bit clock of the right half
        pos_t sl;     // first bit clock of the left word
        pos_t sr;     // first bit clock of the right word
        pos_t wbits;  // word length
        fmt_e fmt;
        logic hiz;
    } geom_t;

    function automatic geom_t calc_geom(input logic [1:0] fmt, input logic [1:0] wcode,
                                        input logic f256, input logic [7:0] off_raw,
                                        input logic hiz);
        geom_t g;
        pos_t  w;
        pos_t  lim;
        pos_t  off;
        pos_t  lead;
        logic  dsp;
        dsp = (fmt == FMT_DSP);
        case (wcode)
            2'b00:   w = pos_t'(16);
            2'b01:   w = pos_t'(20);
            2'b10:   w = pos_t'(24);
            default: w = pos_t'(32);
        endcase
        if (f256) lim = dsp ? pos_t'(241) : pos_t'(242);
        else      lim = dsp ? pos_t'(16)  : pos_t'(17);
        off  = (pos_t'(off_raw) > lim) ? lim : pos_t'(off_raw);
        lead = (fmt == FMT_I2S) ? pos_t'(1) : pos_t'(0);
        if (f256) begin
            g.len  = pos_t'(256);
            g.half = pos_t'(128);
        end else if (dsp) begin
            g.half = w;
            g.len  = (w << 1) + off;
        end else begin
            g.half = w + off + lead;
            g.len  = g.half << 1;
        end
        if (fmt == FMT_RJ) g.sl = (g.half >= w + off) ? (g.half - w - off) : pos_t'(0);
        else               g.sl = off + lead;
        g.sr    = dsp ? (g.sl + w) : (g.sl + g.half);
        g.wbits = w;
        g.fmt   = fmt_e'(fmt);
        g.hiz   = hiz;
        return g;
    endfunction

endpackage

// File: rtl/asp_bclk_gen.sv
module asp_bclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic bclk,
    output logic fall
);
    logic bclk_d, bclk_q;

    always_comb begin
        bclk_d = tick ? ~bclk_q : bclk_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk_d;
    end

    assign bclk = bclk_q;
    assign fall = tick & bclk_q;
endmodule

// File: rtl/asp_sample_hold.sv
module asp_sample_hold #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    input  logic                take,
    output logic                have,
    output logic [SAMPLE_W-1:0] h_left,
    output logic [SAMPLE_W-1:0] h_right
);
    typedef struct packed {
        logic                have;
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d = q;
        if (take) d.have = 1'b0;
        if (s_valid && !q.have) begin
            d.have = 1'b1;
            d.l    = s_left;
            d.r    = s_right;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign s_ready = !q.have;
    assign have    = q.have;
    assign h_left  = q.l;
    assign h_right = q.r;
endmodule

// File: rtl/asp_framer.sv
module asp_framer
    import asp_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall,
    input  logic [1:0]          cfg_fmt,
    input  logic [1:0]          cfg_wlen,
    input  logic                cfg_frame256,
    input  logic [7:0]          cfg_offset,
    input  logic                cfg_hiz,
    input  logic                have,
    input  logic [SAMPLE_W-1:0] h_left,
    input  logic [SAMPLE_W-1:0] h_right,
    output logic                take,
    output logic                wclk,
    output logic                sdata,
    output logic                sdata_oe
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    typedef struct packed {
        logic                running;
        pos_t                cnt;
        geom_t               g;
        logic [SAMPLE_W-1:0] lw;
        logic [SAMPLE_W-1:0] rw;
        logic                wclk;
        logic                sdata;
        logic                oe;
    } frm_t;

    frm_t  d, q;
    geom_t g_in;
    pos_t  pos, kl, kr;
    logic  in_l, in_r, bit_v;
    logic [IDX_W-1:0] il, ir;

    always_comb begin
        g_in = calc_geom(cfg_fmt, cfg_wlen, cfg_frame256, cfg_offset, cfg_hiz);
    end

    always_comb begin
        d     = q;
        take  = 1'b0;
        pos   = '0;
        kl    = '0;
        kr    = '0;
        in_l  = 1'b0;
        in_r  = 1'b0;
        bit_v = 1'b0;
        il    = '0;
        ir    = '0;
        if (fall) begin
            if (!q.running || q.cnt == q.g.len - pos_t'(1)) begin
                d.running = 1'b1;
                d.cnt     = '0;
                d.g       = g_in;
                d.lw      = have ? h_left  : '0;
                d.rw      = have ? h_right : '0;
                take      = have;
            end else begin
                d.cnt = q.cnt + pos_t'(1);
            end
            pos  = d.cnt;
            kl   = pos - d.g.sl;
            kr   = pos - d.g.sr;
            in_l = (pos >= d.g.sl) && (kl < d.g.wbits);
            in_r = !in_l && (pos >= d.g.sr) && (kr < d.g.wbits);
            il   = IDX_W'(d.g.wbits - pos_t'(1) - kl);
            ir   = IDX_W'(d.g.wbits - pos_t'(1) - kr);
            bit_v = in_l ? d.lw[il] : (in_r ? d.rw[ir] : 1'b0);
            case (d.g.fmt)
                FMT_DSP: d.wclk = (pos == '0);
                FMT_I2S: d.wclk = (pos >= d.g.half);
                default: d.wclk = (pos < d.g.half);
            endcase
            d.sdata = bit_v;
            d.oe    = d.g.hiz ? (in_l || in_r) : 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wclk     = q.wclk;
    assign sdata    = q.sdata;
    assign sdata_oe = q.oe;
endmodule

// File: rtl/asp_tx_master.sv
module asp_tx_master #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic [1:0]          cfg_fmt,
    input  logic [1:0]          cfg_wlen,
    input  logic                cfg_frame256,
    input  logic [7:0]          cfg_offset,
    input  logic                cfg_hiz,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                smp_valid,
    output logic                smp_ready,
    output logic                bclk,
    output logic                wclk,
    output logic                sdata,
    output logic                sdata_oe
);
    logic                fall, take, have;
    logic [SAMPLE_W-1:0] h_left, h_right;

    asp_bclk_gen i_bclk (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .bclk  (bclk),
        .fall  (fall)
    );

    asp_sample_hold #(.SAMPLE_W(SAMPLE_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (smp_valid),
        .s_ready (smp_ready),
        .s_left  (smp_left),
        .s_right (smp_right),
        .take    (take),
        .have    (have),
        .h_left  (h_left),
        .h_right (h_right)
    );

    asp_framer #(.SAMPLE_W(SAMPLE_W)) i_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall         (fall),
        .cfg_fmt      (cfg_fmt),
        .cfg_wlen     (cfg_wlen),
        .cfg_frame256 (cfg_frame256),
        .cfg_offset   (cfg_offset),
        .cfg_hiz      (cfg_hiz),
        .have         (have),
        .h_left       (h_left),
        .h_right      (h_right),
        .take         (take),
        .wclk         (wclk),
        .sdata        (sdata),
        .sdata_oe     (sdata_oe)
    );
endmodule

// File: rtl/asp_tx_checker.sv
module asp_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic smp_valid,
    input logic smp_ready,
    input logic bclk,
    input logic wclk,
    input logic sdata,
    input logic sdata_oe
);
    assert_bclk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (bclk != $past(bclk)));

    assert_bclk_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(bclk));

    assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && bclk) |=> ($stable(wclk) && $stable(sdata) && $stable(sdata_oe)));

    assert_wclk_at_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wclk) |-> !bclk);

    assert_quiet_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata);

    assert_one_deep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);
endmodule

bind asp_tx_master asp_tx_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .bclk      (bclk),
    .wclk      (wclk),
    .sdata     (sdata),
    .sdata_oe  (sdata_oe)
);

// File: tb/test_asp_tx_master.sv
module test_asp_tx_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic [1:0]  cfg_fmt = 2'b00;
    logic [1:0]  cfg_wlen = 2'b00;
    logic        cfg_frame256 = 1'b0;
    logic [7:0]  cfg_offset = 8'd0;
    logic        cfg_hiz = 1'b0;
    logic [31:0] smp_left = '0;
    logic [31:0] smp_right = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready, bclk, wclk, sdata, sdata_oe;

    int n_checks = 0;
    int n_errors = 0;
    string tag = "R1";
    logic [63:0] sq[$];
    int  mon_idx = 0;
    int  mon_len = 0;
    int  mon_frame = 0;
    bit  mon_run = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    asp_tx_master i_asp_tx_master (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_frame256(cfg_frame256),
        .cfg_offset(cfg_offset), .cfg_hiz(cfg_hiz),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .bclk(bclk), .wclk(wclk), .sdata(sdata),
        .sdata_oe(sdata_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Independent frame model built from R3..R7
    task automatic model_geo(input int fmt, input int wc, input int f256, input int offr,
                             output int w, output int len, output int half,
                             output int sl, output int sr);
        int lim, off, lead;
        w    = (wc == 0) ? 16 : (wc == 1) ? 20 : (wc == 2) ? 24 : 32;
        lim  = f256 ? ((fmt == 1) ? 241 : 242) : ((fmt == 1) ? 16 : 17);
        off  = (offr > lim) ? lim : offr;
        lead = (fmt == 0) ? 1 : 0;
        if (f256 != 0)     begin len = 256; half = 128; end
        else if (fmt == 1) begin half = w; len = 2 * w + off; end
        else               begin half = w + off + lead; len = 2 * half; end
        if (fmt == 2) sl = (half - w - off > 0) ? half - w - off : 0;
        else          sl = off + lead;
        sr = (fmt == 1) ? sl + w : sl + half;
    endtask

    // bit clock enable every second cycle
    initial begin
        forever begin
            @(negedge clk);
            bit_tick = ~bit_tick;
        end
    end

    // Monitor / scoreboard
    initial begin
        bit   prev_bclk = 1'b0;
        int   since = 0;
        int   s_fmt = 0, s_wc = 0, s_f256 = 0, s_off = 0, s_hiz = 0;
        int   f_fmt = 0, f_hiz = 0, w = 16, half = 0, sl = 0, sr = 0;
        logic [31:0] lw = '0, rw = '0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                since++;
                if (prev_bclk && !bclk) begin
                    int  e_w, e_d, e_v;
                    if (mon_run) chk(since == 4, "R2", "bclk fall spacing", since, 4);
                    since = 0;
                    if (!mon_run || mon_idx == mon_len - 1) begin
                        model_geo(s_fmt, s_wc, s_f256, s_off, w, mon_len, half, sl, sr);
                        f_fmt = s_fmt;
                        f_hiz = s_hiz;
                        mon_idx = 0;
                        mon_run = 1'b1;
                        mon_frame++;
                        if (sq.size() > 0) begin
                            logic [63:0] it;
                            it = sq.pop_front();
                            lw = it[63:32];
                            rw = it[31:0];
                            chk(smp_ready == 1'b1, "R9", "ready after frame start", smp_ready, 1);
                        end else begin
                            lw = '0;
                            rw = '0;
                        end
                    end else begin
                        mon_idx++;
                    end
                    if (f_fmt == 1)      e_w = (mon_idx == 0) ? 1 : 0;
                    else if (f_fmt == 0) e_w = (mon_idx >= half) ? 1 : 0;
                    else                 e_w = (mon_idx < half) ? 1 : 0;
                    e_v = 0; e_d = 0;
                    if (mon_idx >= sl && mon_idx - sl < w) begin
                        e_v = 1; e_d = int'((lw >> (w - 1 - (mon_idx - sl))) & 32'd1);
                    end else if (mon_idx >= sr && mon_idx - sr < w) begin
                        e_v = 1; e_d = int'((rw >> (w - 1 - (mon_idx - sr))) & 32'd1);
                    end
                    chk(int'(wclk) == e_w, {tag, "/R3/R5"}, "wclk", wclk, e_w);
                    chk(int'(sdata) == e_d, {tag, "/R4/R6"}, "sdata", sdata, e_d);
                    chk(int'(sdata_oe) == (f_hiz ? e_v : 1), {tag, "/R8"}, "sdata_oe",
                        sdata_oe, f_hiz ? e_v : 1);
                end
                prev_bclk = bclk;
            end
            s_fmt = cfg_fmt; s_wc = cfg_wlen; s_f256 = cfg_frame256;
            s_off = cfg_offset; s_hiz = cfg_hiz;
        end
    end

    task automatic send(input logic [31:0] l, input logic [31:0] r);
        do @(negedge clk);
        while (!(smp_ready && mon_run && mon_idx >= 1 && mon_idx + 3 < mon_len));
        smp_valid = 1'b1;
        smp_left  = l;
        smp_right = r;
        @(negedge clk);
        sq.push_back({l, r});
        smp_valid = 1'b0;
        #1;
        chk(smp_ready == 1'b0, "R9", "ready low while holding", smp_ready, 0);
    endtask

    task automatic wait_frames(input int n);
        int f0;
        f0 = mon_frame;
        while (mon_frame < f0 + n) @(negedge clk);
    endtask

    task automatic phase(input string t, input logic [1:0] fmt, input logic [1:0] wc,
                         input logic f256, input logic [7:0] off, input logic hz, input int n);
        @(negedge clk);
        cfg_fmt = fmt; cfg_wlen = wc; cfg_frame256 = f256; cfg_offset = off; cfg_hiz = hz;
        wait_frames(1);
        tag = t;
        for (int i = 0; i < n; i++) send($urandom, $urandom);
        wait_frames(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(bclk == 1'b0, "R1", "bclk in reset", bclk, 0);
        chk(wclk == 1'b0, "R1", "wclk in reset", wclk, 0);
        chk(sdata == 1'b0, "R1", "sdata in reset", sdata, 0);
        chk(sdata_oe == 1'b0, "R1", "sdata_oe in reset", sdata_oe, 0);
        chk(smp_ready == 1'b1, "R1", "ready in reset", smp_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        phase("R3",  2'b00, 2'b00, 1'b0, 8'd0,   1'b0, 3);  // I2S 16
        phase("R6",  2'b11, 2'b10, 1'b0, 8'd3,   1'b1, 2);  // LJ 24 off 3
        phase("R5",  2'b10, 2'b01, 1'b1, 8'd10,  1'b1, 2);  // RJ 20, 256 frame
        phase("R4",  2'b01, 2'b11, 1'b0, 8'd5,   1'b0, 3);  // DSP 32
        phase("R7",  2'b00, 2'b00, 1'b0, 8'd200, 1'b1, 2);  // clamp to 17
        phase("R7",  2'b01, 2'b01, 1'b1, 8'd250, 1'b1, 1);  // clamp to 241
        // R9: no samples offered, zeros expected
        @(negedge clk);
        cfg_fmt = 2'b11; cfg_wlen = 2'b00; cfg_frame256 = 1'b0; cfg_offset = 8'd0; cfg_hiz = 1'b1;
        wait_frames(1);
        tag = "R9";
        wait_frames(3);
        // R10: switch from DSP to LJ in the middle of a frame
        phase("R10", 2'b01, 2'b00, 1'b0, 8'd2, 1'b1, 1);
        send(32'h0000_A5C3, 32'h0000_3C5A);
        while (mon_idx < 10) @(negedge clk);
        cfg_fmt = 2'b11; cfg_wlen = 2'b11; cfg_offset = 8'd9; cfg_hiz = 1'b0;
        send(32'hDEAD_BEEF, 32'h1234_5678);
        wait_frames(3);
        finish_run();
    end
endmodule